// File: doc/BRIEF.md
# Hash Command Sequence Checker

This block sits between the software command port of a sponge-based hash and MAC engine and the engine itself. It follows the engine through its phases (idle, message loading, padding, absorbed, squeezing and a locked fault phase) using the commands software issues and the completion flags the engine returns. At every cycle it judges whether the current command is allowed in the current phase. When software opens a new message, it also checks the selected mode and strength, and when MAC operation is enabled it checks the function-name prefix.

An illegal command, an unsupported configuration or a missing-entropy indication raises a combinational command-block signal. That signal freezes the phase tracker for the cycle. A registered error pulse carries a prioritised error code one cycle later. A non-off escalation pattern drives the tracker into the locked phase, which only reset leaves.

Top module: `hash_cmd_guard`

## Requirements
- R1: Reset is active-low and asynchronous. During and after reset, `phase` is 0 (idle), `errValid` is 0 and `errCode` is 0.
- R2: Phase codes are 0 idle, 1 load, 2 pad, 3 ready (absorbed), 4 squeeze and 5 locked. Command codes are 0 none, 1 open, 2 close, 3 more and 4 finish. Idle goes to load on open, but only while `appBusy` is low. Load goes to pad on close. Pad goes to ready only when `absorbedFlag` equals exactly 4'b0110; any other value is ignored. In ready, more goes to squeeze and finish goes to idle. Squeeze returns to ready on `engineDone`. Each move lands on the next clock edge.
- R3: The allowed commands are: idle {none, open}; load {none, close}; ready {none, more, finish}; pad and squeeze {none}. Any other code, including 5 to 7, is a sequence error with code 1. No command is judged in the locked phase.
- R4: Mode and strength are checked only on the idle-to-load move. Mode codes are 0 SHA3, 2 SHAKE and 3 cSHAKE; 1 is reserved. Strength codes are 0 128, 1 224, 2 256, 3 384 and 4 512. SHA3 accepts 224, 256, 384 or 512. SHAKE and cSHAKE accept 128 or 256. Every other pair is a configuration error with code 2.
- R5: On the idle-to-load move with `macEn` high, `prefix` must equal 48'h4341_4D4B_2001. Any other value is a prefix error with code 3, and this error does not block.
- R6: `cmdBlock` is high in the same cycle as any of these: a sequence error; a configuration error while `allowUnsupported` is low; or `entropyNotReady` high (code 4). While it is high, the phase is held at the next edge.
- R7: When several errors coincide, the reported code follows the order sequence (1), configuration (2), prefix (3), entropy (4).
- R8: `errValid` is high for exactly the cycle after each cycle with a detected error, and `errCode` then holds that error's code. Otherwise `errCode` is 0.
- R9: Any `escalate` value other than 4'b1010 forces phase 5 at the next edge, from every phase and even while blocked. Phase 5 is held until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Software command code |
| modeSel | input | 2 | Hash mode selection |
| strengthSel | input | 3 | Security strength selection |
| prefix | input | 48 | Encoded function-name prefix |
| macEn | input | 1 | MAC operation enabled |
| allowUnsupported | input | 1 | Let unsupported mode/strength pairs proceed |
| entropyNotReady | input | 1 | Entropy source reports not ready |
| appBusy | input | 1 | Application interface currently owns the engine |
| absorbedFlag | input | 4 | Multi-bit absorbed indication from the engine |
| engineDone | input | 1 | Squeeze round complete pulse |
| escalate | input | 4 | Multi-bit escalation request |
| errValid | output | 1 | Registered error pulse |
| errCode | output | 3 | Registered error code, 0 when none |
| cmdBlock | output | 1 | Combinational command freeze |
| phase | output | 3 | Tracked engine phase |

## Verification
`cmdBlock` is combinational, so the bench samples it one time unit after driving the inputs, within the same cycle. `phase`, `errValid` and `errCode` each pass through one register. They are due at the first rising edge after the stimulus, and the bench compares them at the following falling edge. A behavioural reference model advances on that same rising edge from the same inputs, so every cycle is compared and no check waits more than one edge.

// File: rtl/hcg_pkg.sv
`timescale 1ns/1ps
package hcg_pkg;
  localparam int CMD_W   = 3;
  localparam int MODE_W  = 2;
  localparam int STR_W   = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP    = 3'd0,
    CMD_OPEN   = 3'd1,
    CMD_CLOSE  = 3'd2,
    CMD_MORE   = 3'd3,
    CMD_FINISH = 3'd4
  } cmd_t;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOAD    = 3'd1,
    PH_PAD     = 3'd2,
    PH_READY   = 3'd3,
    PH_SQUEEZE = 3'd4,
    PH_LOCKED  = 3'd5
  } phase_t;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_ORDER   = 3'd1,
    ERR_CONFIG  = 3'd2,
    ERR_PREFIX  = 3'd3,
    ERR_ENTROPY = 3'd4
  } err_t;

  localparam logic [MODE_W-1:0] MODE_SHA3   = 2'd0;
  localparam logic [MODE_W-1:0] MODE_SHAKE  = 2'd2;
  localparam logic [MODE_W-1:0] MODE_CSHAKE = 2'd3;

  localparam logic [STR_W-1:0] STR_128 = 3'd0;
  localparam logic [STR_W-1:0] STR_224 = 3'd1;
  localparam logic [STR_W-1:0] STR_256 = 3'd2;
  localparam logic [STR_W-1:0] STR_384 = 3'd3;
  localparam logic [STR_W-1:0] STR_512 = 3'd4;

  typedef struct packed {
    phase_t phase;
    logic   enterFeed;
  } strobes_t;
endpackage

// File: rtl/hcg_ctrl.sv
`timescale 1ns/1ps
module hcg_ctrl
  import hcg_pkg::*;
#(
  parameter int               FLAG_W      = 4,
  parameter logic [FLAG_W-1:0] ABSORB_TRUE = 4'b0110,
  parameter logic [FLAG_W-1:0] ESC_OFF     = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  cmdIn,
  input  logic              appBusy,
  input  logic [FLAG_W-1:0] absorbedFlag,
  input  logic              engineDone,
  input  logic [FLAG_W-1:0] escalate,
  input  logic              holdReq,
  output strobes_t          strobes,
  output phase_t            phase
);
  phase_t phaseQ, advance, phaseD;
  logic   escActive;

  assign escActive = (escalate != ESC_OFF);

  always_comb begin
    advance = phaseQ;
    case (phaseQ)
      PH_IDLE:    if (cmdIn == CMD_OPEN && !appBusy) advance = PH_LOAD;
      PH_LOAD:    if (cmdIn == CMD_CLOSE) advance = PH_PAD;
      PH_PAD:     if (absorbedFlag == ABSORB_TRUE) advance = PH_READY;
      PH_READY: begin
        if (cmdIn == CMD_MORE)        advance = PH_SQUEEZE;
        else if (cmdIn == CMD_FINISH) advance = PH_IDLE;
      end
      PH_SQUEEZE: if (engineDone) advance = PH_READY;
      PH_LOCKED:  advance = PH_LOCKED;
      default:    advance = PH_LOCKED;
    endcase
  end

  always_comb begin
    phaseD = holdReq ? phaseQ : advance;
    if (escActive) phaseD = PH_LOCKED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  assign strobes.phase     = phaseQ;
  assign strobes.enterFeed = (phaseQ == PH_IDLE) && (advance == PH_LOAD);
  assign phase             = phaseQ;

  // R9
  escalate_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    escActive |=> phaseQ == PH_LOCKED);

  // R9
  locked_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ == PH_LOCKED |=> phaseQ == PH_LOCKED);

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdReq && !escActive) |=> phaseQ == $past(phaseQ));

  // R2
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ == PH_IDLE |=> phaseQ inside {PH_IDLE, PH_LOAD, PH_LOCKED});
endmodule

// File: rtl/hcg_check.sv
`timescale 1ns/1ps
module hcg_check
  import hcg_pkg::*;
#(
  parameter int                  PREFIX_W   = 48,
  parameter logic [PREFIX_W-1:0] PREFIX_REF = 48'h4341_4D4B_2001
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [CMD_W-1:0]    cmdIn,
  input  logic [MODE_W-1:0]   modeSel,
  input  logic [STR_W-1:0]    strengthSel,
  input  logic [PREFIX_W-1:0] prefix,
  input  logic                macEn,
  input  logic                allowUnsupported,
  input  logic                entropyNotReady,
  output logic                holdReq,
  output logic                errValid,
  output err_t                errCode
);
  logic orderErr, configErr, prefixErr;
  err_t codeD;

  function automatic logic cmdLegal(phase_t ph, logic [CMD_W-1:0] c);
    case (ph)
      PH_IDLE:    return (c == CMD_NOP) || (c == CMD_OPEN);
      PH_LOAD:    return (c == CMD_NOP) || (c == CMD_CLOSE);
      PH_READY:   return (c == CMD_NOP) || (c == CMD_MORE) || (c == CMD_FINISH);
      PH_PAD,
      PH_SQUEEZE: return (c == CMD_NOP);
      default:    return 1'b1;
    endcase
  endfunction

  function automatic logic pairOk(logic [MODE_W-1:0] m, logic [STR_W-1:0] s);
    if (m == MODE_SHA3)
      return (s == STR_224) || (s == STR_256) || (s == STR_384) || (s == STR_512);
    if (m == MODE_SHAKE || m == MODE_CSHAKE)
      return (s == STR_128) || (s == STR_256);
    return 1'b0;
  endfunction

  always_comb begin
    orderErr  = (strobes.phase != PH_LOCKED) && !cmdLegal(strobes.phase, cmdIn);
    configErr = strobes.enterFeed && !pairOk(modeSel, strengthSel);
    prefixErr = strobes.enterFeed && macEn && (prefix != PREFIX_REF);
    holdReq   = orderErr || (configErr && !allowUnsupported) || entropyNotReady;
  end

  always_comb begin
    if (orderErr)             codeD = ERR_ORDER;
    else if (configErr)       codeD = ERR_CONFIG;
    else if (prefixErr)       codeD = ERR_PREFIX;
    else if (entropyNotReady) codeD = ERR_ENTROPY;
    else                      codeD = ERR_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      errValid <= (codeD != ERR_NONE);
      errCode  <= codeD;
    end
  end

  // R8
  pulse_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    errValid == (errCode != ERR_NONE));

  // R4
  config_at_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCode == ERR_CONFIG |-> $past(strobes.enterFeed));

  // R5
  prefix_at_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCode == ERR_PREFIX |-> $past(strobes.enterFeed && macEn));
endmodule

// File: rtl/hash_cmd_guard.sv
`timescale 1ns/1ps
module hash_cmd_guard
  import hcg_pkg::*;
#(
  parameter int                  PREFIX_W    = 48,
  parameter logic [PREFIX_W-1:0] PREFIX_REF  = 48'h4341_4D4B_2001,
  parameter int                  FLAG_W      = 4,
  parameter logic [FLAG_W-1:0]   ABSORB_TRUE = 4'b0110,
  parameter logic [FLAG_W-1:0]   ESC_OFF     = 4'b1010
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cmd,
  input  logic [1:0]          modeSel,
  input  logic [2:0]          strengthSel,
  input  logic [PREFIX_W-1:0] prefix,
  input  logic                macEn,
  input  logic                allowUnsupported,
  input  logic                entropyNotReady,
  input  logic                appBusy,
  input  logic [FLAG_W-1:0]   absorbedFlag,
  input  logic                engineDone,
  input  logic [FLAG_W-1:0]   escalate,
  output logic                errValid,
  output logic [2:0]          errCode,
  output logic                cmdBlock,
  output logic [2:0]          phase
);
  strobes_t strobes;
  phase_t   phaseInt;
  err_t     codeInt;
  logic     holdReq;

  hcg_ctrl #(.FLAG_W(FLAG_W), .ABSORB_TRUE(ABSORB_TRUE), .ESC_OFF(ESC_OFF)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdIn(cmd), .appBusy(appBusy),
    .absorbedFlag(absorbedFlag), .engineDone(engineDone), .escalate(escalate),
    .holdReq(holdReq), .strobes(strobes), .phase(phaseInt)
  );

  hcg_check #(.PREFIX_W(PREFIX_W), .PREFIX_REF(PREFIX_REF)) check_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdIn(cmd), .modeSel(modeSel),
    .strengthSel(strengthSel), .prefix(prefix), .macEn(macEn),
    .allowUnsupported(allowUnsupported), .entropyNotReady(entropyNotReady),
    .holdReq(holdReq), .errValid(errValid), .errCode(codeInt)
  );

  assign errCode  = codeInt;
  assign cmdBlock = holdReq;
  assign phase    = phaseInt;
endmodule

// File: tb/hash_cmd_guard_tb_top.sv
`timescale 1ns/1ps
module hash_cmd_guard_tb_top;
  localparam logic [47:0] GOOD_PFX = 48'h4341_4D4B_2001;
  localparam logic [3:0]  ABS_OK   = 4'b0110;
  localparam logic [3:0]  ESC_IDLE = 4'b1010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic [2:0]  cmd, strengthSel;
  logic [1:0]  modeSel;
  logic [47:0] prefix;
  logic        macEn, allowUnsupported, entropyNotReady, appBusy, engineDone;
  logic [3:0]  absorbedFlag, escalate;
  logic        errValid, cmdBlock;
  logic [2:0]  errCode, phase;

  hash_cmd_guard dut_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .modeSel(modeSel), .strengthSel(strengthSel),
    .prefix(prefix), .macEn(macEn), .allowUnsupported(allowUnsupported),
    .entropyNotReady(entropyNotReady), .appBusy(appBusy), .absorbedFlag(absorbedFlag),
    .engineDone(engineDone), .escalate(escalate), .errValid(errValid),
    .errCode(errCode), .cmdBlock(cmdBlock), .phase(phase)
  );

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";

  // behavioural reference state
  int mPhase = 0;
  int mValid = 0;
  int mCode  = 0;

  function automatic bit allowed(int ph, int c);
    case (ph)
      0: return c == 0 || c == 1;
      1: return c == 0 || c == 2;
      3: return c == 0 || c == 3 || c == 4;
      2, 4: return c == 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit pairGood(int m, int s);
    if (m == 0) return s >= 1 && s <= 4;
    if (m == 2 || m == 3) return s == 0 || s == 2;
    return 1'b0;
  endfunction

  function automatic bit opening();
    return mPhase == 0 && int'(cmd) == 1 && !appBusy;
  endfunction
  function automatic bit seqBad();
    return mPhase != 5 && !allowed(mPhase, int'(cmd));
  endfunction
  function automatic bit cfgBad();
    return opening() && !pairGood(int'(modeSel), int'(strengthSel));
  endfunction
  function automatic bit pfxBad();
    return opening() && macEn && prefix != GOOD_PFX;
  endfunction
  function automatic bit expBlock();
    return seqBad() || (cfgBad() && !allowUnsupported) || entropyNotReady;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase <= 0; mValid <= 0; mCode <= 0;
    end else begin
      int nxt, code;
      nxt = mPhase;
      case (mPhase)
        0: if (opening()) nxt = 1;
        1: if (int'(cmd) == 2) nxt = 2;
        2: if (absorbedFlag == ABS_OK) nxt = 3;
        3: if (int'(cmd) == 3) nxt = 4; else if (int'(cmd) == 4) nxt = 0;
        4: if (engineDone) nxt = 3;
        default: nxt = 5;
      endcase
      if (expBlock()) nxt = mPhase;
      if (escalate != ESC_IDLE) nxt = 5;
      code = seqBad() ? 1 : cfgBad() ? 2 : pfxBad() ? 3 : entropyNotReady ? 4 : 0;
      mPhase <= nxt;
      mCode  <= code;
      mValid <= (code != 0) ? 1 : 0;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic checkRegs();
    check("phase", int'(phase), mPhase);
    check("errValid", int'(errValid), mValid);
    check("errCode", int'(errCode), mCode);
  endtask

  // inputs were set at a falling edge; block is combinational, registers are due after one edge
  task automatic cyc();
    #1 check("cmdBlock", int'(cmdBlock), int'(expBlock()));
    @(posedge clk);
    @(negedge clk);
    checkRegs();
  endtask

  task automatic drive(int c);
    cmd = 3'(c);
    cyc();
    cmd = 3'd0;
  endtask

  task automatic absorbPulse(logic [3:0] v);
    absorbedFlag = v; cyc(); absorbedFlag = 4'b0000;
  endtask

  task automatic openWith(int m, int s);
    modeSel = 2'(m); strengthSel = 3'(s); drive(1);
  endtask

  // from load back to idle along the legal path
  task automatic finishFromLoad();
    drive(2); absorbPulse(ABS_OK); drive(4); drive(0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; cmd = 0; modeSel = 0; strengthSel = 3'd2; prefix = GOOD_PFX;
    macEn = 0; allowUnsupported = 0; entropyNotReady = 0; appBusy = 0;
    absorbedFlag = 0; engineDone = 0; escalate = ESC_IDLE;
    #9;
    curReq = "R1";
    checkRegs();
    @(negedge clk); rstN = 1'b1;
    drive(0);

    // R2 normal SHA3-256 flow with busy hold and non-strict absorbed values
    curReq = "R2";
    appBusy = 1; openWith(0, 2); appBusy = 0;
    openWith(0, 2);
    drive(0);
    drive(2);
    absorbPulse(4'b0111); absorbPulse(4'b1110); absorbPulse(4'b1111);
    absorbPulse(ABS_OK);
    drive(3);
    drive(0);
    engineDone = 1; cyc(); engineDone = 0;
    drive(3);
    engineDone = 1; cyc(); engineDone = 0;
    drive(4);
    drive(0);

    // R3 illegal commands in every tracked phase
    curReq = "R3";
    drive(2); drive(4); drive(7); drive(3);
    openWith(2, 0);
    drive(1); drive(3); drive(5);
    drive(2);
    drive(1); drive(4);
    absorbPulse(ABS_OK);
    drive(1); drive(2); drive(6);
    drive(3);
    drive(2); drive(1);
    engineDone = 1; cyc(); engineDone = 0;
    drive(4); drive(0);

    // R4 mode/strength pairs
    curReq = "R4";
    openWith(1, 2);
    openWith(2, 1);
    openWith(0, 0);
    openWith(3, 4);
    openWith(0, 5);
    openWith(3, 2);
    finishFromLoad();
    openWith(0, 4);
    finishFromLoad();

    // R6 override lets an unsupported pair proceed (still reported); pad hold
    curReq = "R6";
    allowUnsupported = 1; openWith(2, 3); allowUnsupported = 0;
    drive(2);
    cmd = 3'd1; absorbedFlag = ABS_OK; cyc(); cmd = 0;
    cyc(); absorbedFlag = 0;
    entropyNotReady = 1; drive(4); entropyNotReady = 0;
    drive(4); drive(0);

    // R5 prefix check only with MAC enabled
    curReq = "R5";
    modeSel = 2'd3; strengthSel = 3'd0;
    prefix = 48'h4341_4D4B_2002; drive(1);
    finishFromLoad();
    macEn = 1; drive(1);
    finishFromLoad();
    prefix = GOOD_PFX; drive(1);
    finishFromLoad();

    // R7 coincident errors
    curReq = "R7";
    prefix = 48'h0; modeSel = 2'd1; drive(1);
    modeSel = 2'd0; strengthSel = 3'd2;
    entropyNotReady = 1; drive(2);
    drive(1);
    entropyNotReady = 0;
    drive(1);
    finishFromLoad();
    macEn = 0; prefix = GOOD_PFX;

    // R8 pulse returns low
    curReq = "R8";
    drive(3); drive(0); drive(0);
    entropyNotReady = 1; cyc(); cyc(); entropyNotReady = 0; drive(0);

    // R9 escalation from load, stickiness, then escalation while blocked
    curReq = "R9";
    drive(1);
    escalate = 4'b0000; cyc(); escalate = ESC_IDLE;
    drive(2); drive(7); drive(4);
    absorbPulse(ABS_OK);
    drive(0);
    @(negedge clk); rstN = 1'b0; #1;
    curReq = "R1"; checkRegs();
    @(negedge clk); rstN = 1'b1;
    drive(0);
    curReq = "R9";
    cmd = 3'd2; escalate = 4'b1011; cyc(); cmd = 0; escalate = ESC_IDLE;
    drive(1); drive(0);

    summary();
    $finish;
  end
endmodule